// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. It runs on a fast sampling clock. In each reference period it counts the samples in which the phase detector's up or down pulse is active, and that count is the phase error width. When the reference period ends, a one-cycle strobe marks the end, and the block sorts the width against two thresholds. A width below the tight threshold is good. A width above the loose threshold is bad. Anything in between falls in the middle band.

The lock flag rises only after a required number of consecutive good periods. It falls on a single bad period. Two things force it low at once: a new channel being programmed, or the loop being powered down. A precision select picks one of two required run lengths. The gap between the two thresholds forms a hysteresis band, so a flag that is already set does not chatter on marginal errors.

Top module: `pll_lock_detect`

## Requirements
- R1: The error width of a reference period is the number of fast-clock cycles with `pfd_up` or `pfd_dn` high. The count covers every cycle after the previous strobe up to and including the strobe cycle, and it saturates at LOOSE_TH+1.
- R2: `lock_out` rises on the edge that samples a strobe only when that period's width is below TIGHT_TH and it completes the required run of consecutive good periods. The run is RUN_STD (default 40) when `prec_sel`=0 and RUN_ALT (default 5) when `prec_sel`=1.
- R3: A period whose width is at or above TIGHT_TH restarts the run count from zero.
- R4: While locked, a period whose width exceeds LOOSE_TH clears `lock_out` on that strobe's edge.
- R5: A width from TIGHT_TH to LOOSE_TH inclusive leaves `lock_out` unchanged.
- R6: A `new_chan` pulse clears `lock_out`, the run count and the partial width of the current period on the next edge, and it takes priority over a strobe in the same cycle.
- R7: While `pwr_down` is high, the block is held cleared as in R6, and no lock can form. Counting restarts from zero when `pwr_down` is released.
- R8: `lock_out` is 0 after reset and changes only on an edge that samples a strobe or a clear.
- R9: The run count saturates at the larger run length and never wraps, so a long good stretch keeps the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_strobe | input | 1 | One-cycle marker for the last sample of a reference period |
| pfd_up | input | 1 | Phase detector up pulse |
| pfd_dn | input | 1 | Phase detector down pulse |
| prec_sel | input | 1 | Run length select: 0 = RUN_STD, 1 = RUN_ALT |
| new_chan | input | 1 | Pulse when a new channel is programmed |
| pwr_down | input | 1 | Power-down; holds the detector cleared |
| lock_out | output | 1 | Registered lock flag |

## Verification
The checker verifies several rules on every cycle:
- The flag changes only at a strobe or a clear.
- A clear always leaves it low.
- A width above the loose threshold always drops it.
- A middle-band width leaves it untouched.
- It never rises on a width that was not good.
- The run count never passes its ceiling.

Some behaviour only the directed scenarios can show, because it depends on history the checker does not model:
- The exact period on which lock first rises under each precision setting.
- A single marginal period restarting a long run.
- Up and down pulses adding into one width.
- A clear discarding a partly measured period.

// File: rtl/ld_pkg.sv
`timescale 1ns/1ps
package ld_pkg;

   // verdict for one reference period
   typedef enum logic [1:0] {
      EC_NONE = 2'd0,   // no evaluation this cycle
      EC_GOOD = 2'd1,   // width below tight threshold
      EC_MID  = 2'd2,   // inside the hysteresis band
      EC_BAD  = 2'd3    // width above loose threshold
   } err_class_t;

   function automatic err_class_t classify_width(
      input int unsigned width,
      input int unsigned tight,
      input int unsigned loose);
      if (width < tight)
         return EC_GOOD;
      else if (width > loose)
         return EC_BAD;
      else
         return EC_MID;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ld_width_meter.sv
`timescale 1ns/1ps
// Counts sampled phase error per reference period (R1), clears on R6/R7.
module ld_width_meter #(
   parameter int unsigned SAT_CNT = 7,
   parameter int unsigned CW      = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          strobe,
   input  logic          up,
   input  logic          dn,
   output logic [CW-1:0] meas_w
);
   logic active;
   assign active = up | dn;

   generate
      if (SAT_CNT == 1) begin : g_flag
         // a single sticky bit is enough when any error saturates
         logic seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               seen_q <= 1'b0;
            else if (clr || strobe)
               seen_q <= 1'b0;
            else if (active)
               seen_q <= 1'b1;
         end
         assign meas_w = CW'(seen_q | active);
      end else begin : g_count
         logic [CW-1:0] acc_q;
         logic [CW-1:0] acc_plus;
         always_comb begin
            acc_plus = acc_q;
            if (active && (acc_q < CW'(SAT_CNT)))
               acc_plus = acc_q + CW'(1);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               acc_q <= '0;
            else if (clr || strobe)
               acc_q <= '0;
            else
               acc_q <= acc_plus;
         end
         // strobe-cycle sample is part of the period
         assign meas_w = acc_plus;
      end
   endgenerate
endmodule

// File: rtl/ld_run_tracker.sv
`timescale 1ns/1ps
// Consecutive good-period counter (R2, R3, R9).
module ld_run_tracker
   import ld_pkg::*;
#(
   parameter int unsigned RUN_STD = 40,
   parameter int unsigned RUN_ALT = 5,
   parameter int unsigned RUN_MAX = 40,
   parameter int unsigned RW      = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  err_class_t    cls,
   input  logic          prec_sel,
   output logic [RW-1:0] run_q,
   output logic          run_hit
);
   logic [RW-1:0] run_inc;
   logic [RW-1:0] run_req;

   // saturating increment, never wraps (R9)
   assign run_inc = (run_q < RW'(RUN_MAX)) ? run_q + RW'(1) : run_q;
   assign run_req = prec_sel ? RW'(RUN_ALT) : RW'(RUN_STD);
   assign run_hit = (cls == EC_GOOD) && (run_inc >= run_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (clr)
         run_q <= '0;
      else begin
         case (cls)
            EC_GOOD: run_q <= run_inc;
            EC_MID,
            EC_BAD:  run_q <= '0;   // R3
            default: run_q <= run_q;
         endcase
      end
   end
endmodule

// File: rtl/ld_lock_flag.sv
`timescale 1ns/1ps
// Hysteresis lock flag (R2, R4, R5, R8).
module ld_lock_flag
   import ld_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       run_hit,
   input  err_class_t cls,
   output logic       lock_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else if (clr)
         lock_q <= 1'b0;
      else if (run_hit)
         lock_q <= 1'b1;
      else if (cls == EC_BAD)
         lock_q <= 1'b0;
   end
endmodule

// File: rtl/pll_lock_detect.sv
`timescale 1ns/1ps
module pll_lock_detect
   import ld_pkg::*;
#(
   parameter int unsigned TIGHT_TH = 3,
   parameter int unsigned LOOSE_TH = 6,
   parameter int unsigned RUN_STD  = 40,
   parameter int unsigned RUN_ALT  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_strobe,
   input  logic pfd_up,
   input  logic pfd_dn,
   input  logic prec_sel,
   input  logic new_chan,
   input  logic pwr_down,
   output logic lock_out
);
   localparam int unsigned SAT_CNT = LOOSE_TH + 1;
   localparam int unsigned CW      = $clog2(SAT_CNT + 1);
   localparam int unsigned RUN_MAX = max_u(RUN_STD, RUN_ALT);
   localparam int unsigned RW      = $clog2(RUN_MAX + 1);

   initial begin
      if (TIGHT_TH < 1)        $error("TIGHT_TH must be at least 1");
      if (LOOSE_TH < TIGHT_TH) $error("LOOSE_TH must not be below TIGHT_TH");
      if (RUN_STD < 1 || RUN_ALT < 1) $error("run lengths must be at least 1");
   end

   logic          clr;
   logic [CW-1:0] meas_w;
   logic [RW-1:0] run_q;
   logic          run_hit;
   err_class_t    cls;

   // R6 / R7: channel change or power-down clear everything
   assign clr = new_chan | pwr_down;
   assign cls = (ref_strobe && !clr) ? classify_width(32'(meas_w), TIGHT_TH, LOOSE_TH) : EC_NONE;

   ld_width_meter #(.SAT_CNT(SAT_CNT), .CW(CW)) u_meter (
      .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(ref_strobe),
      .up(pfd_up), .dn(pfd_dn), .meas_w(meas_w));

   ld_run_tracker #(.RUN_STD(RUN_STD), .RUN_ALT(RUN_ALT), .RUN_MAX(RUN_MAX), .RW(RW)) u_run (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cls(cls), .prec_sel(prec_sel),
      .run_q(run_q), .run_hit(run_hit));

   ld_lock_flag u_flag (
      .clk(clk), .rst_n(rst_n), .clr(clr), .run_hit(run_hit), .cls(cls),
      .lock_q(lock_out));
endmodule

// File: rtl/ld_checker.sv
`timescale 1ns/1ps
module ld_checker #(
   parameter int unsigned TIGHT_TH = 3,
   parameter int unsigned LOOSE_TH = 6,
   parameter int unsigned RUN_MAX  = 40,
   parameter int unsigned CW       = 3,
   parameter int unsigned RW       = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ref_strobe,
   input logic          new_chan,
   input logic          pwr_down,
   input logic          lock_out,
   input logic [CW-1:0] meas_w,
   input logic [RW-1:0] run_q
);
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (new_chan || pwr_down) |=> !lock_out);   // R6
   AST_BIG_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_strobe && !new_chan && !pwr_down && 32'(meas_w) > LOOSE_TH) |=> !lock_out);   // R4
   AST_MID_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_strobe && !new_chan && !pwr_down && 32'(meas_w) >= TIGHT_TH && 32'(meas_w) <= LOOSE_TH)
      |=> $stable(lock_out));   // R5
   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_strobe && !new_chan && !pwr_down) |=> $stable(lock_out));   // R8
   AST_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_out) |-> $past(ref_strobe && 32'(meas_w) < TIGHT_TH));   // R2
   AST_RUN_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      32'(run_q) <= RUN_MAX);   // R9
endmodule

bind pll_lock_detect ld_checker #(
   .TIGHT_TH(TIGHT_TH), .LOOSE_TH(LOOSE_TH), .RUN_MAX(RUN_MAX), .CW(CW), .RW(RW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_strobe(ref_strobe), .new_chan(new_chan),
   .pwr_down(pwr_down), .lock_out(lock_out), .meas_w(meas_w), .run_q(run_q));

// File: tb/sim_pll_lock_detect.sv
`timescale 1ns/1ps
module sim_pll_lock_detect;
   localparam int LEN = 8;   // fast clocks per reference period

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_strobe = 1'b0, pfd_up = 1'b0, pfd_dn = 1'b0;
   logic prec_sel = 1'b0, new_chan = 1'b0, pwr_down = 1'b0;
   logic lock_out;
   int   n_chk = 0;
   int   n_bad = 0;

   always #2.5 clk = ~clk;

   pll_lock_detect #(.TIGHT_TH(3), .LOOSE_TH(6), .RUN_STD(40), .RUN_ALT(5)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_strobe(ref_strobe), .pfd_up(pfd_up),
      .pfd_dn(pfd_dn), .prec_sel(prec_sel), .new_chan(new_chan),
      .pwr_down(pwr_down), .lock_out(lock_out));

   task automatic chk(input string tag, input logic exp);
      n_chk++;
      if (lock_out !== exp) begin
         n_bad++;
         $display("FAIL %s: lock_out=%b expected=%b at %0t", tag, lock_out, exp, $time);
      end
   endtask

   // one reference period: up for up_n clocks, then dn for dn_n clocks
   task automatic ref_cycle(input int up_n, input int dn_n);
      for (int i = 0; i < LEN; i++) begin
         pfd_up     = (i < up_n);
         pfd_dn     = (i >= up_n) && (i < up_n + dn_n);
         ref_strobe = (i == LEN - 1);
         @(negedge clk);
      end
      pfd_up = 1'b0; pfd_dn = 1'b0; ref_strobe = 1'b0;
   endtask

   task automatic goods(input int n);
      for (int k = 0; k < n; k++) ref_cycle(2, 0);
   endtask

   task automatic clear_pulse();
      new_chan = 1'b1;
      @(negedge clk);
      new_chan = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 reset value", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 after reset release", 1'b0);
   endtask

   task automatic t_std_run();
      prec_sel = 1'b0;
      clear_pulse();
      goods(39);
      chk("R2 std run 39 good", 1'b0);
      ref_cycle(0, 2);
      chk("R2 std run 40th good", 1'b1);
   endtask

   task automatic t_run_break();
      clear_pulse();
      goods(20);
      ref_cycle(3, 0);          // width == tight threshold
      goods(39);
      chk("R3 run restarted", 1'b0);
      goods(1);
      chk("R3 relock after full run", 1'b1);
   endtask

   task automatic t_hysteresis();
      ref_cycle(6, 0);
      chk("R5 width at loose threshold", 1'b1);
      ref_cycle(0, 4);
      chk("R5 mid band width", 1'b1);
      // R8: no change before the strobe of a bad period
      for (int i = 0; i < LEN - 1; i++) begin
         pfd_up = 1'b1;
         @(negedge clk);
      end
      chk("R8 stable before strobe", 1'b1);
      ref_strobe = 1'b1;
      @(negedge clk);
      pfd_up = 1'b0; ref_strobe = 1'b0;
      chk("R4 width 8 above loose drops", 1'b0);
   endtask

   task automatic t_alt_run();
      prec_sel = 1'b1;
      clear_pulse();
      goods(4);
      chk("R2 alt run 4 good", 1'b0);
      goods(1);
      chk("R2 alt run 5th good", 1'b1);
      ref_cycle(7, 0);
      chk("R4 width 7 drops", 1'b0);
   endtask

   task automatic t_width_mix();
      clear_pulse();
      goods(4);
      ref_cycle(2, 2);          // up 2 + dn 2 = 4, not good
      chk("R1 up and dn add", 1'b0);
      goods(4);
      chk("R1 run restarted by sum", 1'b0);
      goods(1);
      chk("R1 lock after fresh run", 1'b1);
   endtask

   task automatic t_new_chan();
      clear_pulse();
      chk("R6 clear drops lock", 1'b0);
      // partial error, then clear mid-period: error must be discarded
      pfd_up = 1'b1;
      repeat (3) @(negedge clk);
      pfd_up = 1'b0;
      new_chan = 1'b1;
      @(negedge clk);
      new_chan = 1'b0;
      @(negedge clk); @(negedge clk);
      ref_strobe = 1'b1;
      @(negedge clk);
      ref_strobe = 1'b0;
      goods(3);
      chk("R6 four good after clear", 1'b0);
      goods(1);
      chk("R6 partial width discarded", 1'b1);
   endtask

   task automatic t_pwr_down();
      pwr_down = 1'b1;
      @(negedge clk);
      chk("R7 power-down drops lock", 1'b0);
      goods(6);
      chk("R7 no lock while powered down", 1'b0);
      pwr_down = 1'b0;
      goods(4);
      chk("R7 count restarts", 1'b0);
      goods(1);
      chk("R7 lock after release", 1'b1);
   endtask

   task automatic t_saturate();
      prec_sel = 1'b0;
      clear_pulse();
      goods(70);
      chk("R9 long good stretch keeps lock", 1'b1);
   endtask

   initial begin
      t_reset();
      t_std_run();
      t_run_break();
      t_hysteresis();
      t_alt_run();
      t_width_mix();
      t_new_chan();
      t_pwr_down();
      t_saturate();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule